// File: doc/BRIEF.md
# Dual-Slot Instruction Packet Issue Controller

This controller accepts one 32-bit fetched instruction word at a time and hands what the word contains to an execution unit. The two top bits of the word choose how the word is read. It can be one long operation. It can be two short operations run one after the other, in either order. It can be two short operations paired for parallel issue. In a parallel pair, a test-only operation decides whether its partner runs.

Each operation is checked against opcode tables that are fixed at elaboration. An operation that misses the table raises a one-cycle illegal-instruction trap, and the rest of the word is dropped. Each operation goes to the execution unit through a valid/ready handshake. The controller then waits for a completion pulse, which carries a PC-changed flag and a condition flag, before it chooses the next slot.

A bank of saturating event counters records the activity. The fetch byte address is taken directly from the program counter.

Top module: `pkt_issue_ctrl`

## Requirements
- R1: Format selector bits [31:30] = 00 is a long word. If the long table holds index bits [29:24], bits [29:0] are issued once with iss_long_o = 1 and role code 0, and long counter slot 0 increments.
- R2: Selector 01 issues the right slot (bits [14:0]) first with role 1, then the left slot (bits [29:15]) with role 2. The right-then-left counter, slot 3, increments when the word is accepted.
- R3: Selector 10 issues the left slot first with role 1, then the right slot with role 2. The left-then-right counter, slot 2, increments when the word is accepted.
- R4: In a sequential pair, if the first slot's completion reports a PC change, the second slot is not issued and jump-skip counter slot 6 increments.
- R5: Selector 11 is a parallel pair. If the left short index is a test-only opcode, the left slot issues first with role 4. The right slot then issues with role 5 only if the completion's condition flag is 1. Cond-true counter slot 4 or cond-false counter slot 5 increments accordingly. When only the right slot is test-only, the two sides swap roles. Parallel counter slot 1 increments when the word is accepted.
- R6: A parallel pair with no test-only slot issues left then right, both with role 3.
- R7: The lookup index is bits [29:24] for a long word and bits [14:9] of a short slot. Long and short opcodes use separate tables. On a miss, trap_o is high for one cycle, unknown counter slot 8 increments, and nothing further from that word is issued. A parallel pair checks both slots before either issues. The second slot of a sequential pair is checked only when it is reached.
- R8: The counters are packed into cnt_flat_o, slot k occupying bits [k*CNT_W +: CNT_W]. They reset to zero and hold at all-ones.
- R9: Cycle counter slot 7 increments once per accepted word, and once more when the second slot of a sequential pair is issued.
- R10: word_ready_o is high only while idle. While iss_valid_o is high and iss_ready_i is low, the issued operation is held unchanged. No further slot is offered until exe_done_i arrives.
- R11: fetch_addr_o equals pc_i shifted left by two bits.
- R12: After reset, word_ready_o = 1, iss_valid_o = 0, trap_o = 0 and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_i | input | PC_W | Current program counter |
| fetch_addr_o | output | PC_W+2 | Fetch byte address |
| word_valid_i | input | 1 | Fetched word present |
| word_i | input | 32 | Fetched instruction word |
| word_ready_o | output | 1 | Controller can take a word |
| iss_valid_o | output | 1 | Operation offered to the execution unit |
| iss_ready_i | input | 1 | Execution unit takes the operation |
| iss_op_o | output | 30 | Operation payload (short slots zero-extended) |
| iss_long_o | output | 1 | Payload is a long operation |
| iss_role_o | output | 3 | Role code: 0 long, 1 sequential first, 2 sequential second, 3 parallel, 4 test, 5 gated |
| exe_done_i | input | 1 | Completion pulse for the last issued operation |
| exe_pc_changed_i | input | 1 | Completed operation changed the PC |
| exe_cond_true_i | input | 1 | Condition result of a completed test operation |
| trap_o | output | 1 | Illegal-instruction trap pulse |
| cnt_flat_o | output | 9*CNT_W | Packed event counters |

## Verification
The hardest case to reach is a sequential pair whose first slot is legal but whose second slot misses the table. In that case the trap comes out after a completion, not when the word is accepted, and it is raised only if that completion reported no PC change. The bench sweeps a grid of left and right opcode indices that straddle the table boundaries, across all four selector codes. Every word is run with each combination of the PC-changed and condition flags, so this case occurs many times. Some words also hold iss_ready_i low to check that the offered operation stays stable. A narrow counter width lets the cycle counter reach saturation within the sweep.

// File: rtl/pkt_issue_pkg.sv
package pkt_issue_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ISS_A, ST_WAIT_A, ST_ISS_B, ST_WAIT_B
    } state_e;

    typedef enum logic [2:0] {
        ROLE_LONG  = 3'd0,
        ROLE_SEQ1  = 3'd1,
        ROLE_SEQ2  = 3'd2,
        ROLE_PAR   = 3'd3,
        ROLE_TEST  = 3'd4,
        ROLE_GATED = 3'd5
    } role_e;

    typedef enum logic [1:0] {
        FMT_LONG = 2'b00, FMT_RL = 2'b01, FMT_LR = 2'b10, FMT_PAR = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        FOL_NONE, FOL_SEQ, FOL_GATED, FOL_PLAIN
    } follow_e;

    localparam int NCNT      = 9;
    localparam int CI_LONG   = 0;
    localparam int CI_PAR    = 1;
    localparam int CI_LR     = 2;
    localparam int CI_RL     = 3;
    localparam int CI_CTRUE  = 4;
    localparam int CI_CFALSE = 5;
    localparam int CI_JUMP   = 6;
    localparam int CI_CYC    = 7;
    localparam int CI_UNK    = 8;

endpackage

// File: rtl/pkt_opcode_lookup.sv
module pkt_opcode_lookup #(
    parameter logic [63:0] LONG_MAP  = '1,
    parameter logic [63:0] SHORT_MAP = '1,
    parameter logic [63:0] TEST_MAP  = '0
) (
    input  logic [5:0] idx_i,
    input  logic       is_long_i,
    output logic       hit_o,
    output logic       test_only_o
);
    always_comb begin
        hit_o       = is_long_i ? LONG_MAP[idx_i] : SHORT_MAP[idx_i];
        test_only_o = !is_long_i && SHORT_MAP[idx_i] && TEST_MAP[idx_i];
    end
endmodule

// File: rtl/pkt_event_counters.sv
module pkt_event_counters #(
    parameter int CW   = 32,
    parameter int NCNT = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCNT-1:0]      inc_i,
    output logic [NCNT*CW-1:0]   cnt_flat_o
);
    logic [NCNT-1:0][CW-1:0] cnt_d, cnt_q;

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        always_comb begin
            cnt_d[g] = cnt_q[g];
            if (inc_i[g] && (cnt_q[g] != {CW{1'b1}})) begin
                cnt_d[g] = cnt_q[g] + 1'b1;
            end
        end
        assign cnt_flat_o[g*CW +: CW] = cnt_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pkt_issue_ctrl.sv
module pkt_issue_ctrl
    import pkt_issue_pkg::*;
#(
    parameter int          PC_W      = 16,
    parameter int          CNT_W     = 32,
    parameter logic [63:0] LONG_MAP  = 64'h7FFF_FFFF_FFFF_FFFF,
    parameter logic [63:0] SHORT_MAP = 64'hFFFF_FFFF_FFFF_FFFF,
    parameter logic [63:0] TEST_MAP  = 64'hF000_0000_0000_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PC_W-1:0]       pc_i,
    output logic [PC_W+1:0]       fetch_addr_o,
    input  logic                  word_valid_i,
    input  logic [31:0]           word_i,
    output logic                  word_ready_o,
    output logic                  iss_valid_o,
    input  logic                  iss_ready_i,
    output logic [29:0]           iss_op_o,
    output logic                  iss_long_o,
    output logic [2:0]            iss_role_o,
    input  logic                  exe_done_i,
    input  logic                  exe_pc_changed_i,
    input  logic                  exe_cond_true_i,
    output logic                  trap_o,
    output logic [NCNT*CNT_W-1:0] cnt_flat_o
);
    localparam int SW = 15;

    typedef struct packed {
        state_e        st;
        logic [29:0]   op_a;
        role_e         role_a;
        logic [SW-1:0] op_b;
        role_e         role_b;
        follow_e       follow;
        logic          trap;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [NCNT-1:0] inc;

    fmt_e          fmt;
    logic [SW-1:0] left_w, right_w;
    logic          hit_hi, test_hi, hit_lo, test_lo, hit_b, test_b_unused;

    assign fmt     = fmt_e'(word_i[31:30]);
    assign left_w  = word_i[29:15];
    assign right_w = word_i[14:0];

    pkt_opcode_lookup #(.LONG_MAP(LONG_MAP), .SHORT_MAP(SHORT_MAP), .TEST_MAP(TEST_MAP))
        u_look_hi (.idx_i(word_i[29:24]), .is_long_i(fmt == FMT_LONG),
                   .hit_o(hit_hi), .test_only_o(test_hi));
    pkt_opcode_lookup #(.LONG_MAP(LONG_MAP), .SHORT_MAP(SHORT_MAP), .TEST_MAP(TEST_MAP))
        u_look_lo (.idx_i(word_i[14:9]), .is_long_i(1'b0),
                   .hit_o(hit_lo), .test_only_o(test_lo));
    pkt_opcode_lookup #(.LONG_MAP(LONG_MAP), .SHORT_MAP(SHORT_MAP), .TEST_MAP(TEST_MAP))
        u_look_b (.idx_i(ctl_q.op_b[14:9]), .is_long_i(1'b0),
                  .hit_o(hit_b), .test_only_o(test_b_unused));

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.trap = 1'b0;
        inc        = '0;
        unique case (ctl_q.st)
            ST_IDLE: if (word_valid_i) begin
                inc[CI_CYC] = 1'b1;
                unique case (fmt)
                    FMT_LONG: begin
                        if (!hit_hi) begin
                            ctl_d.trap = 1'b1; inc[CI_UNK] = 1'b1;
                        end else begin
                            inc[CI_LONG]  = 1'b1;
                            ctl_d.op_a    = word_i[29:0];
                            ctl_d.role_a  = ROLE_LONG;
                            ctl_d.follow  = FOL_NONE;
                            ctl_d.st      = ST_ISS_A;
                        end
                    end
                    FMT_RL, FMT_LR: begin
                        inc[(fmt == FMT_RL) ? CI_RL : CI_LR] = 1'b1;
                        if (!((fmt == FMT_RL) ? hit_lo : hit_hi)) begin
                            ctl_d.trap = 1'b1; inc[CI_UNK] = 1'b1;
                        end else begin
                            ctl_d.op_a   = {15'd0, (fmt == FMT_RL) ? right_w : left_w};
                            ctl_d.op_b   = (fmt == FMT_RL) ? left_w : right_w;
                            ctl_d.role_a = ROLE_SEQ1;
                            ctl_d.role_b = ROLE_SEQ2;
                            ctl_d.follow = FOL_SEQ;
                            ctl_d.st     = ST_ISS_A;
                        end
                    end
                    default: begin
                        inc[CI_PAR] = 1'b1;
                        if (!(hit_hi && hit_lo)) begin
                            ctl_d.trap = 1'b1; inc[CI_UNK] = 1'b1;
                        end else begin
                            ctl_d.st = ST_ISS_A;
                            if (test_hi) begin
                                ctl_d.op_a   = {15'd0, left_w};
                                ctl_d.op_b   = right_w;
                                ctl_d.role_a = ROLE_TEST;
                                ctl_d.role_b = ROLE_GATED;
                                ctl_d.follow = FOL_GATED;
                            end else if (test_lo) begin
                                ctl_d.op_a   = {15'd0, right_w};
                                ctl_d.op_b   = left_w;
                                ctl_d.role_a = ROLE_TEST;
                                ctl_d.role_b = ROLE_GATED;
                                ctl_d.follow = FOL_GATED;
                            end else begin
                                ctl_d.op_a   = {15'd0, left_w};
                                ctl_d.op_b   = right_w;
                                ctl_d.role_a = ROLE_PAR;
                                ctl_d.role_b = ROLE_PAR;
                                ctl_d.follow = FOL_PLAIN;
                            end
                        end
                    end
                endcase
            end
            ST_ISS_A: if (iss_ready_i) ctl_d.st = ST_WAIT_A;
            ST_WAIT_A: if (exe_done_i) begin
                unique case (ctl_q.follow)
                    FOL_NONE: ctl_d.st = ST_IDLE;
                    FOL_SEQ: begin
                        if (exe_pc_changed_i) begin
                            inc[CI_JUMP] = 1'b1; ctl_d.st = ST_IDLE;
                        end else if (!hit_b) begin
                            ctl_d.trap = 1'b1; inc[CI_UNK] = 1'b1; ctl_d.st = ST_IDLE;
                        end else begin
                            inc[CI_CYC] = 1'b1; ctl_d.st = ST_ISS_B;
                        end
                    end
                    FOL_GATED: begin
                        if (exe_cond_true_i) begin
                            inc[CI_CTRUE] = 1'b1; ctl_d.st = ST_ISS_B;
                        end else begin
                            inc[CI_CFALSE] = 1'b1; ctl_d.st = ST_IDLE;
                        end
                    end
                    default: ctl_d.st = ST_ISS_B;
                endcase
            end
            ST_ISS_B:  if (iss_ready_i) ctl_d.st = ST_WAIT_B;
            ST_WAIT_B: if (exe_done_i)  ctl_d.st = ST_IDLE;
            default:   ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, op_a: '0, role_a: ROLE_LONG, op_b: '0,
                       role_b: ROLE_LONG, follow: FOL_NONE, trap: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pkt_event_counters #(.CW(CNT_W), .NCNT(NCNT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(inc), .cnt_flat_o(cnt_flat_o)
    );

    assign fetch_addr_o = {pc_i, 2'b00};
    assign word_ready_o = (ctl_q.st == ST_IDLE);
    assign iss_valid_o  = (ctl_q.st == ST_ISS_A) || (ctl_q.st == ST_ISS_B);
    assign iss_op_o     = (ctl_q.st == ST_ISS_B) ? {15'd0, ctl_q.op_b} : ctl_q.op_a;
    assign iss_role_o   = (ctl_q.st == ST_ISS_B) ? ctl_q.role_b : ctl_q.role_a;
    assign iss_long_o   = (ctl_q.st == ST_ISS_A) && (ctl_q.role_a == ROLE_LONG);
    assign trap_o       = ctl_q.trap;
endmodule

// File: rtl/pkt_issue_chk.sv
module pkt_issue_chk #(
    parameter int CW   = 32,
    parameter int NCNT = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               word_ready_o,
    input logic               iss_valid_o,
    input logic               iss_ready_i,
    input logic [29:0]        iss_op_o,
    input logic               exe_done_i,
    input logic               exe_pc_changed_i,
    input logic               trap_o,
    input logic [NCNT*CW-1:0] cnt_flat_o
);
    logic [CW-1:0] cyc_cnt, jump_cnt, unk_cnt;
    assign cyc_cnt  = cnt_flat_o[7*CW +: CW];
    assign jump_cnt = cnt_flat_o[6*CW +: CW];
    assign unk_cnt  = cnt_flat_o[8*CW +: CW];

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid_o && !iss_ready_i) |=> (iss_valid_o && $stable(iss_op_o)));

    assert_trap_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (word_ready_o && !iss_valid_o));

    assert_trap_counted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && (unk_cnt != {CW{1'b1}})) |-> (unk_cnt != $past(unk_cnt)));

    assert_jump_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_cnt != $past(jump_cnt)) |-> $past(exe_done_i && exe_pc_changed_i));

    assert_cyc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_cnt - $past(cyc_cnt)) <= CW'(1));
endmodule

bind pkt_issue_ctrl pkt_issue_chk #(.CW(CNT_W), .NCNT(pkt_issue_pkg::NCNT)) u_chk (
    .clk(clk), .rst_n(rst_n), .word_ready_o(word_ready_o), .iss_valid_o(iss_valid_o),
    .iss_ready_i(iss_ready_i), .iss_op_o(iss_op_o), .exe_done_i(exe_done_i),
    .exe_pc_changed_i(exe_pc_changed_i), .trap_o(trap_o), .cnt_flat_o(cnt_flat_o)
);

// File: tb/tb_pkt_issue_ctrl.sv
`timescale 1ns/1ps
module tb_pkt_issue_ctrl;
    localparam int CW = 10;
    localparam int PW = 16;
    localparam int NC = 9;
    localparam int SAT = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PW-1:0] pc = '0;
    logic [PW+1:0] faddr;
    logic word_valid = 1'b0;
    logic [31:0] word = '0;
    logic word_ready, iss_valid, iss_long, trap;
    logic iss_ready = 1'b1;
    logic [29:0] iss_op;
    logic [2:0] iss_role;
    logic exe_done = 1'b0, exe_pcch = 1'b0, exe_cond = 1'b0;
    logic [NC*CW-1:0] cnt_flat;

    always #2.5 clk = ~clk;

    pkt_issue_ctrl #(
        .PC_W(PW), .CNT_W(CW),
        .LONG_MAP(64'h0000_0000_FFFF_FFFF),
        .SHORT_MAP(64'h00FF_FFFF_FFFF_FFFF),
        .TEST_MAP(64'h00FF_0000_0000_0000)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pc_i(pc), .fetch_addr_o(faddr),
        .word_valid_i(word_valid), .word_i(word), .word_ready_o(word_ready),
        .iss_valid_o(iss_valid), .iss_ready_i(iss_ready), .iss_op_o(iss_op),
        .iss_long_o(iss_long), .iss_role_o(iss_role), .exe_done_i(exe_done),
        .exe_pc_changed_i(exe_pcch), .exe_cond_true_i(exe_cond),
        .trap_o(trap), .cnt_flat_o(cnt_flat)
    );

    int checks = 0, errors = 0;
    int exp_cnt [NC];
    logic [29:0] got_op [4];
    logic [2:0]  got_role [4];
    logic        got_long [4];
    int got_n;
    bit got_trap;
    logic [29:0] ex_op [2];
    logic [2:0]  ex_role [2];
    int ex_n;
    bit ex_trap;

    function automatic bit long_ok(int i);  return i < 32; endfunction
    function automatic bit short_ok(int i); return i < 56; endfunction
    function automatic bit test_ok(int i);  return i >= 48 && i < 56; endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic bump(int i);
        if (exp_cnt[i] < SAT) exp_cnt[i]++;
    endtask

    task automatic add_exp(logic [29:0] op, logic [2:0] role);
        ex_op[ex_n] = op; ex_role[ex_n] = role; ex_n++;
    endtask

    // Model of R1-style decode, computed from the requirement text
    task automatic model(logic [31:0] w, bit pcch, bit cnd);
        int li, ri;
        logic [29:0] lw, rw;
        li = int'(w[29:24]); ri = int'(w[14:9]);
        lw = {15'd0, w[29:15]}; rw = {15'd0, w[14:0]};
        ex_n = 0; ex_trap = 0;
        bump(7);
        case (w[31:30])
            2'b00: begin // R1
                if (!long_ok(li)) begin ex_trap = 1; bump(8); end
                else begin bump(0); add_exp(w[29:0], 3'd0); end
            end
            2'b01, 2'b10: begin // R2 R3 R4
                logic [29:0] f, s; int fi, si;
                if (w[31:30] == 2'b01) begin bump(3); f = rw; s = lw; fi = ri; si = li; end
                else begin bump(2); f = lw; s = rw; fi = li; si = ri; end
                if (!short_ok(fi)) begin ex_trap = 1; bump(8); end
                else begin
                    add_exp(f, 3'd1);
                    if (pcch) bump(6);
                    else if (!short_ok(si)) begin ex_trap = 1; bump(8); end
                    else begin bump(7); add_exp(s, 3'd2); end
                end
            end
            default: begin // R5 R6
                bump(1);
                if (!short_ok(li) || !short_ok(ri)) begin ex_trap = 1; bump(8); end
                else if (test_ok(li) || test_ok(ri)) begin
                    add_exp(test_ok(li) ? lw : rw, 3'd4);
                    if (cnd) begin bump(4); add_exp(test_ok(li) ? rw : lw, 3'd5); end
                    else bump(5);
                end else begin
                    add_exp(lw, 3'd3); add_exp(rw, 3'd3);
                end
            end
        endcase
    endtask

    task automatic run_word(logic [31:0] w, bit pcch, bit cnd, bit stall);
        got_n = 0; got_trap = 0;
        iss_ready = !stall;
        exe_pcch = pcch; exe_cond = cnd;
        @(negedge clk); word_valid = 1'b1; word = w;
        @(negedge clk); word_valid = 1'b0;
        for (int k = 0; k < 12; k++) begin
            if (trap) got_trap = 1;
            if (iss_valid) begin
                if (got_n < 4) begin
                    got_op[got_n] = iss_op; got_role[got_n] = iss_role;
                    got_long[got_n] = iss_long; got_n++;
                end
                if (stall) begin
                    for (int s = 0; s < 2; s++) begin
                        @(negedge clk);
                        chk(iss_valid && iss_op == got_op[got_n-1], "R10", "held op",
                            longint'(iss_op), longint'(got_op[got_n-1]));
                    end
                    iss_ready = 1'b1;
                end
                @(negedge clk);
                chk(!iss_valid && !word_ready, "R10", "waiting for done", iss_valid, 0);
                exe_done = 1'b1; iss_ready = !stall;
                @(negedge clk);
                exe_done = 1'b0;
            end else if (word_ready) begin
                break;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic compare(logic [31:0] w);
        string tag;
        tag = (w[31:30] == 2'b00) ? "R1" : (w[31:30] == 2'b01) ? "R2" :
              (w[31:30] == 2'b10) ? "R3" : "R5";
        chk(got_trap == ex_trap, "R7", "trap", got_trap, ex_trap);
        chk(got_n == ex_n, tag, "issue count", got_n, ex_n);
        for (int i = 0; i < ex_n && i < got_n; i++) begin
            chk(got_op[i] == ex_op[i], tag, "op", longint'(got_op[i]), longint'(ex_op[i]));
            chk(got_role[i] == ex_role[i], tag, "role", got_role[i], ex_role[i]);
            chk(got_long[i] == (ex_role[i] == 3'd0), "R1", "long flag",
                got_long[i], (ex_role[i] == 3'd0));
        end
        for (int c = 0; c < NC; c++) begin
            chk(int'(cnt_flat[c*CW +: CW]) == exp_cnt[c], (c == 7) ? "R9" : "R8",
                $sformatf("counter %0d", c), longint'(cnt_flat[c*CW +: CW]), exp_cnt[c]);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) exp_cnt[c] = 0;
        repeat (3) @(negedge clk);
        // R12
        chk(word_ready == 1'b1, "R12", "word_ready", word_ready, 1);
        chk(iss_valid == 1'b0 && trap == 1'b0, "R12", "idle outputs", {iss_valid, trap}, 0);
        chk(cnt_flat == '0, "R12", "counters", longint'(cnt_flat[63:0]), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11
        for (int p = 0; p < 8; p++) begin
            pc = PW'(p * 8191 + 3);
            #0.1;
            chk(faddr == {pc, 2'b00}, "R11", "fetch address", faddr, {pc, 2'b00});
        end
        // Sweep: selector x left index x right index x flags
        for (int f = 0; f < 4; f++) begin
            for (int li = 0; li < 64; li += 7) begin
                for (int ri = 0; ri < 64; ri += 5) begin
                    for (int fl = 0; fl < 4; fl++) begin
                        logic [31:0] w;
                        bit st;
                        w = {2'(f), 6'(li), 9'((li * 37 + ri) & 511), 6'(ri), 9'((ri * 11 + fl) & 511)};
                        st = (((li + ri + fl) % 9) == 0);
                        model(w, fl[0], fl[1]);
                        run_word(w, fl[0], fl[1], st);
                        compare(w);
                    end
                end
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule